// File: doc/BRIEF.md
# Two-Level Device Address Translation Walker

This block turns a 32-bit device virtual address into a physical address for one stream. It reads two levels of 64-bit descriptors from memory, using 16 KiB pages. The caller presents a request that carries the stream number, the virtual address, the stream's mode and the stream's four table base page numbers, each with a valid flag. The block issues up to two descriptor reads on a simple memory read port. It then returns either a physical address or a fault. A faulting response carries a cause code and echoes the virtual address and stream number, so that the surrounding logic can capture them.

The walker handles one request at a time. The request and response sides each use a valid/ready handshake. The memory port uses a request valid/ready pair and a response valid strobe, and the walker accepts that strobe whenever it is waiting for data. The physical address field in both descriptor levels is stored shifted right by the parameter `SHIFT`, which is 0 or 4. The walker shifts the field back left before it uses it.

Top module: `dva_walker`

## Requirements
- R1: `req_ready_o` is high only while no walk is in progress. A response holds `rsp_valid_o` and all response fields stable until `rsp_ready_i` is sampled high. After that the walker is ready again on the next cycle.
- R2: Mode 2 (bypass) returns the virtual address, zero-extended, as the physical address with no fault. It makes no memory read, and the response is valid in the cycle after the request is accepted.
- R3: Mode 0 or mode 3 (translation disabled) returns cause 1 with no memory read. The response is valid in the cycle after acceptance.
- R4: In mode 1 (translate), the base register is selected by the virtual address bits above bit 35. With 32-bit addresses these bits are zero, so base 0 is always used. If the selected base is flagged invalid, the walker returns cause 2 with no memory read. Otherwise the first read address is {base page, va[35:25], 3'b000}, where the address bits beyond the top of the virtual address are zero.
- R5: A first-level entry whose bits [1:0] equal 2'b11 points to a second-level table. That table's page is ((entry[35:0] << SHIFT) >> 14). Any other first-level entry returns cause 3 after one read.
- R6: The second read address is {second-level page, va[24:14], 3'b000}.
- R7: A leaf with bit 0 clear, including the all-zero leaf, returns cause 4.
- R8: A valid leaf with bit 1 (full page) set ignores its window. Without bit 1, the word offset va[13:2] must satisfy start <= offset <= end, where start is leaf[63:52] and end is leaf[51:40]. Both bounds are inclusive. A word offset outside that range returns cause 5.
- R9: A successful walk returns the physical address {((leaf[35:0] << SHIFT) >> 14), va[13:0]} with cause 0. With no memory stall, the response is valid four cycles after acceptance.
- R10: Every response echoes the accepted virtual address and stream number. A faulting response sets `rsp_fault_o` and drives a physical address of zero.
- R11: `mem_req_valid_o` and `mem_addr_o` stay stable until `mem_req_ready_i` is sampled high. A stalled memory port delays the result but does not change it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Translate request valid |
| req_ready_o | output | 1 | Walker idle, request accepted this cycle |
| req_sid_i | input | SID_W | Stream number |
| req_va_i | input | VA_W | Device virtual address |
| req_mode_i | input | 2 | 0/3 disabled, 1 translate, 2 bypass |
| req_base_i | input | N_BASE x BASE_W | First-level table page numbers |
| req_base_vld_i | input | N_BASE | Valid flag per base |
| rsp_valid_o | output | 1 | Response valid |
| rsp_ready_i | input | 1 | Response taken |
| rsp_fault_o | output | 1 | Translation fault |
| rsp_cause_o | output | 3 | 0 ok, 1 disabled, 2 base, 3 first level, 4 leaf, 5 window |
| rsp_pa_o | output | PA_W | Physical address |
| rsp_va_o | output | VA_W | Virtual address of this response |
| rsp_sid_o | output | SID_W | Stream number of this response |
| mem_req_valid_o | output | 1 | Descriptor read request |
| mem_req_ready_i | input | 1 | Read request accepted |
| mem_addr_o | output | PA_W | Descriptor byte address |
| mem_rsp_valid_i | input | 1 | Read data valid |
| mem_rsp_data_i | input | 64 | Descriptor data |

## Verification
Each request is accepted on a clock edge, and the number of edges before the response appears depends on the path the walk takes. Bypass, disabled and invalid-base responses appear after the accepting edge. A first-level fault appears two edges later, and a full walk appears four edges later, when a memory model answers one cycle after each read is accepted. The bench counts falling edges from acceptance and requires `rsp_valid_o` on exactly the predicted one. It compares every field against a behavioural walk of its own memory image, and it compares every issued read address against the addresses that walk predicts. The latency check is skipped only for the stalled-memory case, where the result must still match.

// File: rtl/walker_pkg.sv
package walker_pkg;
  localparam int PAGE_BITS = 14;
  localparam int IDX_W     = 11;
  localparam int OFF4_W    = PAGE_BITS - 2;
  localparam int ENT_W     = 64;

  localparam logic [1:0] MODE_OFF    = 2'd0;
  localparam logic [1:0] MODE_XLATE  = 2'd1;
  localparam logic [1:0] MODE_BYPASS = 2'd2;

  localparam logic [2:0] CAUSE_NONE = 3'd0;
  localparam logic [2:0] CAUSE_OFF  = 3'd1;
  localparam logic [2:0] CAUSE_BASE = 3'd2;
  localparam logic [2:0] CAUSE_L1   = 3'd3;
  localparam logic [2:0] CAUSE_LEAF = 3'd4;
  localparam logic [2:0] CAUSE_WIN  = 3'd5;

  typedef enum logic [2:0] {
    ST_IDLE, ST_L1_REQ, ST_L1_WAIT, ST_L2_REQ, ST_L2_WAIT, ST_RESP
  } walk_state_e;
endpackage

// File: rtl/ptw_index.sv
module ptw_index import walker_pkg::*; #(
  parameter int VA_W   = 32,
  parameter int TSEL_W = 2
) (
  input  logic [VA_W-1:0]   va_i,
  output logic [IDX_W-1:0]  l1_idx_o,
  output logic [IDX_W-1:0]  l2_idx_o,
  output logic [TSEL_W-1:0] tsel_o,
  output logic [OFF4_W-1:0] off4_o
);
  localparam int EXT_W = PAGE_BITS + 2*IDX_W + TSEL_W;

  logic [EXT_W-1:0] va_ext;

  generate
    if (VA_W >= EXT_W) begin : g_trunc
      assign va_ext = va_i[EXT_W-1:0];
      if (VA_W > EXT_W) begin : g_hi
        logic unused_hi;
        assign unused_hi = ^va_i[VA_W-1:EXT_W];
      end
    end else begin : g_ext
      assign va_ext = {{(EXT_W-VA_W){1'b0}}, va_i};
    end
  endgenerate

  logic unused_byte;
  assign unused_byte = ^va_ext[1:0];

  assign off4_o   = va_ext[PAGE_BITS-1:2];
  assign l2_idx_o = va_ext[PAGE_BITS +: IDX_W];
  assign l1_idx_o = va_ext[PAGE_BITS+IDX_W +: IDX_W];
  assign tsel_o   = va_ext[EXT_W-1 -: TSEL_W];
endmodule

// File: rtl/ptw_l1_check.sv
module ptw_l1_check import walker_pkg::*; #(
  parameter int FLD_W = 36,
  parameter int SHIFT = 4,
  localparam int PA_W = FLD_W + SHIFT
) (
  input  logic [ENT_W-1:0]          entry_i,
  output logic                      ok_o,
  output logic [PA_W-PAGE_BITS-1:0] page_o
);
  logic [PA_W-1:0] pa_full;
  assign pa_full = PA_W'(entry_i[FLD_W-1:0]) << SHIFT;
  assign page_o  = pa_full[PA_W-1:PAGE_BITS];
  assign ok_o    = (entry_i[1:0] == 2'b11);

  logic unused_l1;
  assign unused_l1 = ^{entry_i[ENT_W-1:FLD_W], pa_full[PAGE_BITS-1:0]};
endmodule

// File: rtl/ptw_leaf_check.sv
module ptw_leaf_check import walker_pkg::*; #(
  parameter int FLD_W = 36,
  parameter int SHIFT = 4,
  localparam int PA_W = FLD_W + SHIFT
) (
  input  logic [ENT_W-1:0]          entry_i,
  input  logic [OFF4_W-1:0]         off4_i,
  output logic [2:0]                cause_o,
  output logic [PA_W-PAGE_BITS-1:0] page_o
);
  logic [OFF4_W-1:0] win_lo, win_hi;
  logic [PA_W-1:0]   pa_full;

  assign win_lo  = entry_i[63:52];
  assign win_hi  = entry_i[51:40];
  assign pa_full = PA_W'(entry_i[FLD_W-1:0]) << SHIFT;
  assign page_o  = pa_full[PA_W-1:PAGE_BITS];

  always_comb begin
    if (!entry_i[0])                                       cause_o = CAUSE_LEAF;
    else if (!entry_i[1] && (off4_i < win_lo || off4_i > win_hi)) cause_o = CAUSE_WIN;
    else                                                   cause_o = CAUSE_NONE;
  end

  logic unused_pa;
  assign unused_pa = ^pa_full[PAGE_BITS-1:0];

  generate
    if (FLD_W < 40) begin : g_gap
      logic unused_gap;
      assign unused_gap = ^entry_i[39:FLD_W];
    end
  endgenerate
endmodule

// File: rtl/dva_walker.sv
module dva_walker import walker_pkg::*; #(
  parameter int VA_W   = 32,
  parameter int SID_W  = 8,
  parameter int N_BASE = 4,
  parameter int FLD_W  = 36,
  parameter int SHIFT  = 4,
  localparam int PA_W   = FLD_W + SHIFT,
  localparam int BASE_W = PA_W - PAGE_BITS,
  localparam int TSEL_W = (N_BASE > 1) ? $clog2(N_BASE) : 1
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           req_valid_i,
  output logic                           req_ready_o,
  input  logic [SID_W-1:0]               req_sid_i,
  input  logic [VA_W-1:0]                req_va_i,
  input  logic [1:0]                     req_mode_i,
  input  logic [N_BASE-1:0][BASE_W-1:0]  req_base_i,
  input  logic [N_BASE-1:0]              req_base_vld_i,
  output logic                           rsp_valid_o,
  input  logic                           rsp_ready_i,
  output logic                           rsp_fault_o,
  output logic [2:0]                     rsp_cause_o,
  output logic [PA_W-1:0]                rsp_pa_o,
  output logic [VA_W-1:0]                rsp_va_o,
  output logic [SID_W-1:0]               rsp_sid_o,
  output logic                           mem_req_valid_o,
  input  logic                           mem_req_ready_i,
  output logic [PA_W-1:0]                mem_addr_o,
  input  logic                           mem_rsp_valid_i,
  input  logic [ENT_W-1:0]               mem_rsp_data_i
);
  walk_state_e       state_q;
  logic [VA_W-1:0]   va_q;
  logic [SID_W-1:0]  sid_q;
  logic [BASE_W-1:0] page_q;
  logic [PA_W-1:0]   pa_q;
  logic [2:0]        cause_q;

  logic [VA_W-1:0]   va_sel;
  logic [IDX_W-1:0]  l1_idx, l2_idx;
  logic [TSEL_W-1:0] tsel;
  logic [OFF4_W-1:0] off4;
  logic              l1_ok;
  logic [BASE_W-1:0] l1_page, leaf_page;
  logic [2:0]        leaf_cause;

  // index logic is shared: incoming address while idle, held address while walking
  assign va_sel = (state_q == ST_IDLE) ? req_va_i : va_q;

  ptw_index #(.VA_W(VA_W), .TSEL_W(TSEL_W)) u_index (
    .va_i(va_sel), .l1_idx_o(l1_idx), .l2_idx_o(l2_idx), .tsel_o(tsel), .off4_o(off4)
  );

  ptw_l1_check #(.FLD_W(FLD_W), .SHIFT(SHIFT)) u_l1 (
    .entry_i(mem_rsp_data_i), .ok_o(l1_ok), .page_o(l1_page)
  );

  ptw_leaf_check #(.FLD_W(FLD_W), .SHIFT(SHIFT)) u_leaf (
    .entry_i(mem_rsp_data_i), .off4_i(off4), .cause_o(leaf_cause), .page_o(leaf_page)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      va_q    <= '0;
      sid_q   <= '0;
      page_q  <= '0;
      pa_q    <= '0;
      cause_q <= CAUSE_NONE;
    end else begin
      unique case (state_q)
        ST_IDLE: if (req_valid_i) begin
          va_q    <= req_va_i;
          sid_q   <= req_sid_i;
          pa_q    <= '0;
          cause_q <= CAUSE_NONE;
          if (req_mode_i == MODE_BYPASS) begin
            pa_q    <= PA_W'(req_va_i);
            state_q <= ST_RESP;
          end else if (req_mode_i != MODE_XLATE) begin
            cause_q <= CAUSE_OFF;
            state_q <= ST_RESP;
          end else if (!req_base_vld_i[tsel]) begin
            cause_q <= CAUSE_BASE;
            state_q <= ST_RESP;
          end else begin
            page_q  <= req_base_i[tsel];
            state_q <= ST_L1_REQ;
          end
        end
        ST_L1_REQ: if (mem_req_ready_i) state_q <= ST_L1_WAIT;
        ST_L1_WAIT: if (mem_rsp_valid_i) begin
          if (l1_ok) begin
            page_q  <= l1_page;
            state_q <= ST_L2_REQ;
          end else begin
            cause_q <= CAUSE_L1;
            state_q <= ST_RESP;
          end
        end
        ST_L2_REQ: if (mem_req_ready_i) state_q <= ST_L2_WAIT;
        ST_L2_WAIT: if (mem_rsp_valid_i) begin
          cause_q <= leaf_cause;
          if (leaf_cause == CAUSE_NONE) pa_q <= {leaf_page, va_q[PAGE_BITS-1:0]};
          state_q <= ST_RESP;
        end
        ST_RESP: if (rsp_ready_i) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready_o     = (state_q == ST_IDLE);
  assign mem_req_valid_o = (state_q == ST_L1_REQ) || (state_q == ST_L2_REQ);
  assign mem_addr_o      = {page_q, (state_q == ST_L1_REQ) ? l1_idx : l2_idx, 3'b000};
  assign rsp_valid_o     = (state_q == ST_RESP);
  assign rsp_fault_o     = (cause_q != CAUSE_NONE);
  assign rsp_cause_o     = cause_q;
  assign rsp_pa_o        = pa_q;
  assign rsp_va_o        = va_q;
  assign rsp_sid_o       = sid_q;
endmodule

// File: rtl/dva_walker_checker.sv
module dva_walker_checker import walker_pkg::*; #(
  parameter int VA_W = 32,
  parameter int PA_W = 40
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            req_valid_i,
  input logic            req_ready_o,
  input logic [VA_W-1:0] req_va_i,
  input logic [1:0]      req_mode_i,
  input logic            rsp_valid_o,
  input logic            rsp_ready_i,
  input logic            rsp_fault_o,
  input logic [2:0]      rsp_cause_o,
  input logic [PA_W-1:0] rsp_pa_o,
  input logic [VA_W-1:0] rsp_va_o,
  input logic            mem_req_valid_o,
  input logic            mem_req_ready_i,
  input logic [PA_W-1:0] mem_addr_o
);
  logic [VA_W-1:0] va_cap;
  logic            acc;
  assign acc = req_valid_i && req_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  va_cap <= '0;
    else if (acc) va_cap <= req_va_i;
  end

  AST_IDLE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> !rsp_valid_o && !mem_req_valid_o);  // R1
  AST_RSP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && !rsp_ready_i |=> rsp_valid_o && $stable(rsp_pa_o) && $stable(rsp_cause_o)); // R1
  AST_BYPASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc && req_mode_i == MODE_BYPASS |=> rsp_valid_o && !rsp_fault_o && !mem_req_valid_o
      && rsp_pa_o == PA_W'($past(req_va_i)));  // R2
  AST_DISABLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc && req_mode_i != MODE_BYPASS && req_mode_i != MODE_XLATE
      |=> rsp_valid_o && rsp_cause_o == CAUSE_OFF && !mem_req_valid_o);  // R3
  AST_PA_OFFSET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && !rsp_fault_o |-> rsp_pa_o[PAGE_BITS-1:0] == va_cap[PAGE_BITS-1:0]); // R9
  AST_ECHO_VA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> rsp_va_o == va_cap);  // R10
  AST_FAULT_PA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && rsp_fault_o |-> rsp_pa_o == '0);  // R10
  AST_MEM_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_valid_o && !mem_req_ready_i |=> mem_req_valid_o && $stable(mem_addr_o)); // R11
endmodule

bind dva_walker dva_walker_checker #(.VA_W(VA_W), .PA_W(PA_W)) u_chk (.*);

// File: tb/tb_dva_walker.sv
module tb_dva_walker;
  localparam int VA_W = 32, SID_W = 8, NB = 4, PA_W = 40, BW = 26;

  logic clk = 0, rst_n = 0;
  always #5 clk = ~clk;

  logic                 req_valid = 0, rsp_ready = 0, mem_ready = 1, mem_rvalid = 0;
  logic [SID_W-1:0]     req_sid = 0;
  logic [VA_W-1:0]      req_va = 0;
  logic [1:0]           req_mode = 0;
  logic [NB-1:0][BW-1:0] bases;
  logic [NB-1:0]        bvld;
  logic [63:0]          mem_rdata = 0;
  logic                 req_ready_o, rsp_valid_o, rsp_fault_o, mem_req_valid_o;
  logic [2:0]           rsp_cause_o;
  logic [PA_W-1:0]      rsp_pa_o, mem_addr_o;
  logic [VA_W-1:0]      rsp_va_o;
  logic [SID_W-1:0]     rsp_sid_o;

  dva_walker dut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ready_o(req_ready_o),
    .req_sid_i(req_sid), .req_va_i(req_va), .req_mode_i(req_mode), .req_base_i(bases),
    .req_base_vld_i(bvld), .rsp_valid_o(rsp_valid_o), .rsp_ready_i(rsp_ready),
    .rsp_fault_o(rsp_fault_o), .rsp_cause_o(rsp_cause_o), .rsp_pa_o(rsp_pa_o),
    .rsp_va_o(rsp_va_o), .rsp_sid_o(rsp_sid_o), .mem_req_valid_o(mem_req_valid_o),
    .mem_req_ready_i(mem_ready), .mem_addr_o(mem_addr_o), .mem_rsp_valid_i(mem_rvalid),
    .mem_rsp_data_i(mem_rdata)
  );

  int checks = 0, failures = 0;
  bit [63:0] mem [bit [39:0]];
  logic [39:0] got_q[$];
  int stall_cnt = 0;

  function automatic bit [63:0] rd(bit [39:0] a);
    return mem.exists(a) ? mem[a] : 64'h0;
  endfunction

  task automatic chk(string r, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s: actual=%0h expected=%0h", r, what, act, exp);
    end
  endtask

  // memory model: answers one cycle after each accepted read
  initial begin
    bit pend = 0;
    bit [39:0] paddr = 0;
    forever begin
      @(negedge clk);
      mem_rvalid = 0;
      if (pend) begin mem_rvalid = 1; mem_rdata = rd(paddr); pend = 0; end
      if (stall_cnt > 0) begin mem_ready = 0; stall_cnt--; end
      else mem_ready = 1;
      if (mem_req_valid_o && mem_ready) begin
        pend = 1; paddr = mem_addr_o; got_q.push_back(mem_addr_o);
      end
    end
  end

  task automatic ref_walk(input logic [31:0] va, input logic [1:0] mode,
                          output bit f, output int c, output logic [39:0] pa,
                          ref logic [39:0] q[$]);
    logic [63:0] e, pg;
    int ts, o, s, en;
    q.delete(); f = 0; c = 0; pa = 0;
    if (mode == 2) begin pa = 40'(va); return; end
    if (mode != 1) begin f = 1; c = 1; return; end
    ts = int'((64'(va) >> 36) & 3);
    if (!bvld[ts]) begin f = 1; c = 2; return; end
    q.push_back(40'((64'(bases[ts]) << 14) + ((64'(va) >> 25) & 'h7ff) * 8));
    e = rd(q[0]);
    if (e[1:0] != 2'b11) begin f = 1; c = 3; return; end
    pg = ((e & 64'hF_FFFF_FFFF) << 4) & ~64'h3fff;
    q.push_back(40'(pg + ((64'(va) >> 14) & 'h7ff) * 8));
    e = rd(q[1]);
    if (!e[0]) begin f = 1; c = 4; return; end
    o = int'((va >> 2) & 'hfff); s = int'(e[63:52]); en = int'(e[51:40]);
    if (!e[1] && (o < s || o > en)) begin f = 1; c = 5; return; end
    pa = 40'((((e & 64'hF_FFFF_FFFF) << 4) & ~64'h3fff) | (64'(va) & 'h3fff));
  endtask

  task automatic xact(input logic [31:0] va, input logic [1:0] mode, input logic [7:0] sid,
                      input int hold, input int lat, input string r);
    bit ef; int ec; logic [39:0] epa; logic [39:0] eq[$];
    logic [39:0] pa_seen;
    int n = 0;
    ref_walk(va, mode, ef, ec, epa, eq);
    got_q.delete();
    @(negedge clk);
    chk("R1", "ready before request", 64'(req_ready_o), 64'd1);
    req_valid = 1; req_va = va; req_mode = mode; req_sid = sid;
    @(posedge clk); #1 req_valid = 0;
    forever begin
      @(negedge clk); n++;
      if (rsp_valid_o || n > 60) break;
    end
    if (lat >= 0) chk(r, "response cycle", 64'(n), 64'(lat + 1));
    chk(r, "fault", 64'(rsp_fault_o), 64'(ef));
    chk(r, "cause", 64'(rsp_cause_o), 64'(ec));
    chk(r, "pa", 64'(rsp_pa_o), 64'(epa));
    chk("R10", "va echo", 64'(rsp_va_o), 64'(va));
    chk("R10", "sid echo", 64'(rsp_sid_o), 64'(sid));
    chk(r, "read count", 64'(got_q.size()), 64'(eq.size()));
    foreach (eq[i]) if (i < got_q.size()) chk(r, "read addr", 64'(got_q[i]), 64'(eq[i]));
    pa_seen = rsp_pa_o;
    for (int k = 0; k < hold; k++) begin
      @(negedge clk);
      chk("R1", "rsp held", 64'(rsp_valid_o), 64'd1);
      chk("R1", "pa held", 64'(rsp_pa_o), 64'(pa_seen));
    end
    rsp_ready = 1;
    @(posedge clk); #1 rsp_ready = 0;
    @(negedge clk);
    chk("R1", "ready after response", 64'(req_ready_o), 64'd1);
  endtask

  function automatic logic [63:0] ptr(int page);
    return (64'(page) << 10) | 64'h3;
  endfunction
  function automatic logic [63:0] leaf(int pp, int fl, int s, int e);
    return (64'(s) << 52) | (64'(e) << 40) | (64'(pp) << 10) | 64'(fl);
  endfunction
  function automatic logic [31:0] mkva(int l1, int l2, int off);
    return 32'((l1 << 25) | (l2 << 14) | off);
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    bases = '{default: 26'h3ffffff};
    bases[0] = 26'h100;
    bvld = 4'b0001;
    mem[40'((64'h100 << 14) + 0 * 8)] = ptr('h200);
    mem[40'((64'h100 << 14) + 1 * 8)] = ptr('h201);
    mem[40'((64'h100 << 14) + 5 * 8)] = (64'h300 << 10) | 64'h1;
    mem[40'((64'h200 << 14) + 'h101 * 8)] = leaf('h5a5a, 3, 0, 'hfff);
    mem[40'((64'h200 << 14) + 'h103 * 8)] = leaf('h1234, 1, 'h10, 'h20);
    mem[40'((64'h200 << 14) + 'h104 * 8)] = leaf('h777, 3, 'h10, 'h20);
    mem[40'((64'h200 << 14) + 'h105 * 8)] = leaf('h999, 2, 0, 'hfff);
    mem[40'((64'h201 << 14) + 0 * 8)]     = leaf('h2abcde, 3, 0, 'hfff);

    repeat (3) @(negedge clk);
    chk("R1", "reset rsp_valid", 64'(rsp_valid_o), 64'd0);
    chk("R11", "reset mem_req_valid", 64'(mem_req_valid_o), 64'd0);
    rst_n = 1;
    @(negedge clk);
    chk("R1", "idle after reset", 64'(req_ready_o), 64'd1);

    xact(32'hdead_beef, 2'd2, 8'h11, 0, 0, "R2");
    xact(32'h0000_1000, 2'd0, 8'h12, 0, 0, "R3");
    xact(32'h0000_2004, 2'd3, 8'h13, 0, 0, "R3");
    bvld = 4'b1110;
    xact(mkva(0, 'h101, 0), 2'd1, 8'h14, 0, 0, "R4");
    bvld = 4'b0001;
    xact(mkva(0, 'h101, 'h2ab), 2'd1, 8'h15, 0, 4, "R9");
    xact(mkva(1, 0, 'h3ffc), 2'd1, 8'h16, 0, 4, "R5");
    xact(mkva(5, 0, 0), 2'd1, 8'h17, 0, 2, "R5");
    xact(mkva(0, 'h102, 0), 2'd1, 8'h18, 0, 4, "R7");
    xact(mkva(0, 'h105, 'h40), 2'd1, 8'h19, 0, 4, "R7");
    xact(mkva(0, 'h103, 'h40), 2'd1, 8'h1a, 0, 4, "R8");
    xact(mkva(0, 'h103, 'h83), 2'd1, 8'h1b, 0, 4, "R8");
    xact(mkva(0, 'h103, 'h3c), 2'd1, 8'h1c, 0, 4, "R8");
    xact(mkva(0, 'h103, 'h84), 2'd1, 8'h1d, 0, 4, "R8");
    xact(mkva(0, 'h104, 'h3000), 2'd1, 8'h1e, 0, 4, "R8");
    xact(mkva(1, 0, 'h10), 2'd1, 8'h1f, 0, 4, "R6");
    xact(32'h0bad_f00d, 2'd2, 8'h20, 3, 0, "R1");
    stall_cnt = 3;
    xact(mkva(0, 'h101, 'h123), 2'd1, 8'h21, 2, -1, "R11");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule